// File: doc/BRIEF.md
# I2C Bus Wiring Probe

This block runs once after power-up, or whenever it is asked to, and finds out which of up to three two-wire serial buses are wired and pulled up. It probes the buses one at a time, lowest index first. Each probe sends a STOP condition and then applies two fixed patterns of clock and data levels. After each pattern it reads both lines back. A bus that gives the expected levels for both patterns is marked present and gets a closing STOP. A bus that gives wrong levels is left released, and the probe moves on to the next bus. No device is addressed and no byte is moved.

Each bus connects through open-drain drive-low enables (`scl_lo_o`, `sda_lo_o`). Each bus also has line inputs that the surrounding logic has already synchronised. Time is counted in units of `T_CYC` clock cycles; every wait below is a whole number of units. The state machine has these states:

- `ST_IDLE`, `ST_CLEAR`, `ST_PRE`
- `ST_STOP_A`, `ST_STOP_B`, `ST_STOP_C`
- `ST_GAP`, `ST_P1_SCL`, `ST_P1_SDA`, `ST_P1_CHK`
- `ST_P2_HOLD`, `ST_P2_SCL`, `ST_P2_SDA`, `ST_P2_CHK`
- `ST_MARK`, `ST_NEXT`, `ST_DONE`

It moves through them as follows:

- **Starting a run.** `ST_IDLE` moves to `ST_CLEAR` on a start pulse.
- **Opening STOP.** `ST_CLEAR` moves to `ST_PRE`, then on to `ST_STOP_A`, `ST_STOP_B` and `ST_STOP_C` as each wait runs out.
- **After the STOP.** `ST_STOP_C` goes to `ST_GAP` on the opening STOP. On the closing STOP it goes to `ST_NEXT` instead.
- **First pattern.** `ST_GAP` moves to `ST_P1_SCL`, then `ST_P1_SDA`, then `ST_P1_CHK`. From `ST_P1_CHK` the machine goes to `ST_P2_HOLD` on a good read and to `ST_NEXT` on a bad one.
- **Second pattern.** `ST_P2_HOLD` moves to `ST_P2_SCL`, then `ST_P2_SDA`, then `ST_P2_CHK`. From `ST_P2_CHK` the machine goes to `ST_MARK` on a good read and to `ST_NEXT` on a bad one.
- **Closing STOP.** `ST_MARK` goes back to `ST_STOP_A`, which starts the closing STOP.
- **Between buses.** `ST_NEXT` goes to `ST_CLEAR` for the next bus, or to `ST_DONE` after the last bus.
- **End of run.** `ST_DONE` returns to `ST_IDLE`.

Top module: `i2c_wire_probe`

## Requirements
- R1: After reset, all drive-low outputs are 0 (both lines released on every bus), and `present_o`, `pass_o`, `done_o` and `busy_o` are 0. While `busy_o` is 0, no line on any bus is driven low.
- R2: A `start_i` pulse while `busy_o` is 0 begins a run. A `start_i` pulse while `busy_o` is 1, including the cycle in which `done_o` is 1, has no effect: the run length, the mask and `busy_o` are unchanged.
- R3: `three_bus_i` is sampled with the accepted start. At 1, buses 0, 1 and 2 are probed. At 0, only buses 0 and 1 are probed; bus 2 is never driven low, and `present_o[2]` stays 0.
- R4: Buses are probed in ascending index order. At most one bus has any line driven low in any cycle.
- R5: Each bus probe opens with one idle cycle, then 2T released, then a STOP. The STOP holds both lines low for T, then releases SCL with SDA low for 3T, then releases both for 2T.
- R6: After the opening STOP, both lines stay released for another 2T. Pattern one then drives SCL low with SDA released for 2T. It then checks the lines for one cycle, and the bus fails if SCL reads high or SDA reads low.
- R7: Pattern two keeps SCL low for a further T. It then releases SCL for T, then drives SDA low with SCL released for T. It then checks the lines for one cycle, and the bus fails if SCL reads low or SDA reads high.
- R8: A bus that passes both checks holds SDA low with SCL released for T more. It then receives a closing STOP like the one in R5, followed by one idle cycle. A failing bus is released at once, gets no closing STOP, and the next bus begins after one idle cycle. Per-bus lengths are 22T+4 cycles for a passing bus, 15T+4 for a failure at pattern two, and 12T+3 for a failure at pattern one.
- R9: `done_o` is 1 for exactly one cycle, 1 + the sum of the per-bus lengths after the start edge. `pass_o` is 1 exactly when at least one probed bus is present. The mask and `pass_o` are cleared on the accepted start and then held until the next accepted start.
- R10: Bit i of `present_o` (and of every per-bus vector) belongs to bus i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, acted on only when idle |
| three_bus_i | input | 1 | 1: probe three buses, 0: probe two |
| scl_in_i | input | 3 | Synchronised clock-line level, one bit per bus |
| sda_in_i | input | 3 | Synchronised data-line level, one bit per bus |
| scl_lo_o | output | 3 | Clock-line drive-low enable, one bit per bus |
| sda_lo_o | output | 3 | Data-line drive-low enable, one bit per bus |
| present_o | output | 3 | Bus present mask |
| pass_o | output | 1 | At least one probed bus present |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| busy_o | output | 1 | Run in progress |

## Verification
Two events can land in the same cycle: a new start request and the end-of-run pulse. `done_o` is still part of a busy run, so the start must be dropped. The bench raises `start_i` exactly in the `done_o` cycle. It then checks that `busy_o` stays low and the mask does not change. A second collision, a stray start in the middle of a run, is judged by checking that the run length is exactly the value computed from the per-bus fault pattern.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    localparam int BUS_MAX = 3;
    localparam int BUS_IW  = $clog2(BUS_MAX);
    localparam int UNIT_W  = 2;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_PRE,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C,
        ST_GAP,
        ST_P1_SCL,
        ST_P1_SDA,
        ST_P1_CHK,
        ST_P2_HOLD,
        ST_P2_SCL,
        ST_P2_SDA,
        ST_P2_CHK,
        ST_MARK,
        ST_NEXT,
        ST_DONE
    } probe_st_e;

    typedef struct packed {
        logic scl_lo;
        logic sda_lo;
    } line_req_t;

    // Length of each timed state in units of T; zero means a single cycle.
    function automatic logic [UNIT_W-1:0] st_units(probe_st_e s);
        logic [UNIT_W-1:0] u;
        unique case (s)
            ST_PRE, ST_STOP_C, ST_GAP:       u = 2'd2;
            ST_STOP_B:                       u = 2'd3;
            ST_STOP_A, ST_P1_SCL, ST_P1_SDA,
            ST_P2_HOLD, ST_P2_SCL, ST_P2_SDA,
            ST_MARK:                         u = 2'd1;
            default:                         u = 2'd0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/i2cp_timer.sv
module i2cp_timer #(
    parameter int T_CYC  = 250,
    parameter int UNIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [UNIT_W-1:0] units_i,
    output logic              expired_o
);

    localparam int MAX_CYC = T_CYC * ((1 << UNIT_W) - 1);
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            if (units_i == '0) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= CW'(int'(units_i) * T_CYC - 1);
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/i2cp_line_drv.sv
module i2cp_line_drv
    import i2cp_pkg::*;
#(
    parameter int NB = BUS_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_IW-1:0] idx_i,
    input  line_req_t         req_i,
    output logic [NB-1:0]     scl_lo_o,
    output logic [NB-1:0]     sda_lo_o
);

    logic [NB-1:0] scl_d;
    logic [NB-1:0] sda_d;

    // Steer the requested levels to the selected bus only.
    for (genvar g = 0; g < NB; g++) begin : g_bus
        assign scl_d[g] = req_i.scl_lo && (idx_i == BUS_IW'(g));
        assign sda_d[g] = req_i.sda_lo && (idx_i == BUS_IW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_lo_o <= '0;
            sda_lo_o <= '0;
        end else begin
            scl_lo_o <= scl_d;
            sda_lo_o <= sda_d;
        end
    end

endmodule

// File: rtl/i2cp_result.sv
module i2cp_result
    import i2cp_pkg::*;
#(
    parameter int NB = BUS_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              mark_i,
    input  logic [BUS_IW-1:0] idx_i,
    input  logic              latch_i,
    output logic [NB-1:0]     present_o,
    output logic              pass_o
);

    logic [NB-1:0] hit;

    for (genvar g = 0; g < NB; g++) begin : g_hit
        assign hit[g] = mark_i && (idx_i == BUS_IW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            present_o <= '0;
            pass_o    <= 1'b0;
        end else if (clear_i) begin
            present_o <= '0;
            pass_o    <= 1'b0;
        end else begin
            present_o <= present_o | hit;
            if (latch_i) begin
                pass_o <= |present_o;
            end
        end
    end

endmodule

// File: rtl/i2c_wire_probe.sv
module i2c_wire_probe
    import i2cp_pkg::*;
#(
    parameter int T_CYC = 250
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               three_bus_i,
    input  logic [BUS_MAX-1:0] scl_in_i,
    input  logic [BUS_MAX-1:0] sda_in_i,
    output logic [BUS_MAX-1:0] scl_lo_o,
    output logic [BUS_MAX-1:0] sda_lo_o,
    output logic [BUS_MAX-1:0] present_o,
    output logic               pass_o,
    output logic               done_o,
    output logic               busy_o
);

    probe_st_e         st_q, st_d;
    logic [BUS_IW-1:0] idx_q;
    logic [BUS_IW-1:0] last_idx;
    logic              three_q;
    logic              closing_q;
    logic              tmr_exp;
    logic              scl_cur, sda_cur;
    logic              p1_ok, p2_ok;
    line_req_t         req;
    logic              clear_req, mark_req, latch_req;

    assign last_idx = three_q ? BUS_IW'(2) : BUS_IW'(1);
    assign scl_cur  = scl_in_i[idx_q];
    assign sda_cur  = sda_in_i[idx_q];
    assign p1_ok    = !scl_cur && sda_cur;
    assign p2_ok    = scl_cur && !sda_cur;

    i2cp_timer #(
        .T_CYC  (T_CYC),
        .UNIT_W (UNIT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (st_d != st_q),
        .units_i   (st_units(st_d)),
        .expired_o (tmr_exp)
    );

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start_i) st_d = ST_CLEAR;
            ST_CLEAR:   st_d = ST_PRE;
            ST_PRE:     if (tmr_exp) st_d = ST_STOP_A;
            ST_STOP_A:  if (tmr_exp) st_d = ST_STOP_B;
            ST_STOP_B:  if (tmr_exp) st_d = ST_STOP_C;
            ST_STOP_C:  if (tmr_exp) st_d = closing_q ? ST_NEXT : ST_GAP;
            ST_GAP:     if (tmr_exp) st_d = ST_P1_SCL;
            ST_P1_SCL:  if (tmr_exp) st_d = ST_P1_SDA;
            ST_P1_SDA:  if (tmr_exp) st_d = ST_P1_CHK;
            ST_P1_CHK:  st_d = p1_ok ? ST_P2_HOLD : ST_NEXT;
            ST_P2_HOLD: if (tmr_exp) st_d = ST_P2_SCL;
            ST_P2_SCL:  if (tmr_exp) st_d = ST_P2_SDA;
            ST_P2_SDA:  if (tmr_exp) st_d = ST_P2_CHK;
            ST_P2_CHK:  st_d = p2_ok ? ST_MARK : ST_NEXT;
            ST_MARK:    if (tmr_exp) st_d = ST_STOP_A;
            ST_NEXT:    st_d = (idx_q == last_idx) ? ST_DONE : ST_CLEAR;
            ST_DONE:    st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Run context: bus index, bus count, opening or closing STOP.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            three_q   <= 1'b0;
            closing_q <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && start_i) begin
                idx_q     <= '0;
                three_q   <= three_bus_i;
                closing_q <= 1'b0;
            end
            if (st_q == ST_MARK && tmr_exp) begin
                closing_q <= 1'b1;
            end
            if (st_q == ST_NEXT) begin
                closing_q <= 1'b0;
                if (idx_q != last_idx) begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        req = '{scl_lo: 1'b0, sda_lo: 1'b0};
        unique case (st_q)
            ST_STOP_A:                        req = '{scl_lo: 1'b1, sda_lo: 1'b1};
            ST_STOP_B:                        req = '{scl_lo: 1'b0, sda_lo: 1'b1};
            ST_P1_SCL, ST_P1_SDA, ST_P1_CHK,
            ST_P2_HOLD:                       req = '{scl_lo: 1'b1, sda_lo: 1'b0};
            ST_P2_SDA, ST_P2_CHK, ST_MARK:    req = '{scl_lo: 1'b0, sda_lo: 1'b1};
            default:                          req = '{scl_lo: 1'b0, sda_lo: 1'b0};
        endcase
        busy_o    = (st_q != ST_IDLE);
        done_o    = (st_q == ST_DONE);
        clear_req = (st_q == ST_IDLE) && start_i;
        mark_req  = (st_q == ST_MARK);
        latch_req = (st_q == ST_NEXT) && (idx_q == last_idx);
    end

    i2cp_line_drv #(
        .NB (BUS_MAX)
    ) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_i    (idx_q),
        .req_i    (req),
        .scl_lo_o (scl_lo_o),
        .sda_lo_o (sda_lo_o)
    );

    i2cp_result #(
        .NB (BUS_MAX)
    ) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_req),
        .mark_i    (mark_req),
        .idx_i     (idx_q),
        .latch_i   (latch_req),
        .present_o (present_o),
        .pass_o    (pass_o)
    );

endmodule

// File: rtl/i2cp_checker.sv
module i2cp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       pass_o,
    input logic [2:0] present_o,
    input logic [2:0] scl_lo_o,
    input logic [2:0] sda_lo_o,
    input logic       three_q
);

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (scl_lo_o == 3'b000 && sda_lo_o == 3'b000)); // R1

    AST_ONE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(scl_lo_o | sda_lo_o) <= 1); // R4

    AST_THIRD_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !three_q |-> (!scl_lo_o[2] && !sda_lo_o[2] && !present_o[2])); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(present_o) && $stable(pass_o)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_PASS_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o == (present_o != 3'b000))); // R9

endmodule

bind i2c_wire_probe i2cp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .present_o (present_o),
    .scl_lo_o  (scl_lo_o),
    .sda_lo_o  (sda_lo_o),
    .three_q   (three_q)
);

// File: tb/i2c_wire_probe_tb.sv
module i2c_wire_probe_tb;

    localparam int T = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       three = 1'b0;
    logic [2:0] scl_in, sda_in, scl_lo, sda_lo, present;
    logic       pass, done, busy;

    int fault [3];
    int errors = 0;
    int checks = 0;
    int cyc = 0;

    bit run_three;
    bit mon_multi, mon_order, mon_b2;
    int last_bus;
    int nseg, cur_len;
    logic [1:0] cur_code;
    logic [1:0] seg_code [16];
    int seg_len [16];

    always #5 clk = ~clk;

    i2c_wire_probe #(.T_CYC(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .three_bus_i(three),
        .scl_in_i(scl_in), .sda_in_i(sda_in), .scl_lo_o(scl_lo), .sda_lo_o(sda_lo),
        .present_o(present), .pass_o(pass), .done_o(done), .busy_o(busy)
    );

    // Fault codes: 0 good, 1 SCL no pull-up, 2 SDA no pull-up,
    // 3 SCL stuck high, 4 SDA stuck high, 5 SCL and SDA shorted.
    function automatic logic [1:0] line_rd(int f, logic sl, logic dl);
        logic s, d;
        s = !sl;
        d = !dl;
        case (f)
            1: s = 1'b0;
            2: d = 1'b0;
            3: s = 1'b1;
            4: d = 1'b1;
            5: begin s = s & d; d = s; end
            default: ;
        endcase
        return {s, d};
    endfunction

    always_comb begin
        for (int b = 0; b < 3; b++) begin
            {scl_in[b], sda_in[b]} = line_rd(fault[b], scl_lo[b], sda_lo[b]);
        end
    end

    function automatic int bus_cycles(int f);
        if (f == 0) return 22 * T + 4;
        if (f == 1 || f == 4) return 15 * T + 4;
        return 12 * T + 3;
    endfunction

    function automatic int exp_len(bit thr);
        int s = 1;
        for (int b = 0; b < (thr ? 3 : 2); b++) s += bus_cycles(fault[b]);
        return s;
    endfunction

    function automatic logic [2:0] exp_mask(bit thr);
        logic [2:0] m = 3'b000;
        for (int b = 0; b < (thr ? 3 : 2); b++) m[b] = (fault[b] == 0);
        return m;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Bus activity and segment monitor, sampled away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                int ndrv;
                ndrv = 0;
                for (int b = 0; b < 3; b++) begin
                    if (scl_lo[b] | sda_lo[b]) begin
                        ndrv++;
                        if (b < last_bus) mon_order = 1'b1;
                        last_bus = b;
                    end
                end
                if (ndrv > 1) mon_multi = 1'b1;
                if (!run_three && (scl_lo[2] | sda_lo[2])) mon_b2 = 1'b1;
            end
            if ({scl_lo[0], sda_lo[0]} != cur_code) begin
                if (nseg < 16) begin
                    seg_code[nseg] = cur_code;
                    seg_len[nseg]  = cur_len;
                end
                nseg++;
                cur_code = {scl_lo[0], sda_lo[0]};
                cur_len  = 1;
            end else begin
                cur_len++;
            end
        end
    end

    task automatic run_case(bit thr, bit stray, bit at_done);
        int n = 0;
        bit seen = 0;
        logic [2:0] early = 3'b000;
        logic [2:0] held;
        @(negedge clk);
        start = 1'b1; three = thr; run_three = thr;
        mon_multi = 0; mon_order = 0; mon_b2 = 0; last_bus = 0;
        nseg = 0; cur_len = 0; cur_code = 2'b00;
        while (!seen && n < 6000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = stray && (n == 20);
            three = 1'b0;
            if (n == 2) early = present;
            if (done) seen = 1;
        end
        chk(seen, "R9", "done pulse seen", seen, 1);
        chk(n == exp_len(thr), "R8", "run length", n, exp_len(thr));
        chk(early == 3'b000, "R9", "mask cleared at start", early, 0);
        chk(present == exp_mask(thr), "R10", "present mask", present, exp_mask(thr));
        chk(pass == (exp_mask(thr) != 0), "R9", "pass flag", pass, exp_mask(thr) != 0);
        chk(!mon_multi, "R4", "one bus driven at a time", mon_multi, 0);
        chk(!mon_order, "R4", "ascending bus order", mon_order, 0);
        chk(!mon_b2, "R3", "bus 2 idle in two-bus mode", mon_b2, 0);
        if (stray) chk(n == exp_len(thr), "R2", "start while busy ignored", n, exp_len(thr));
        held = present;
        if (at_done) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R9", "done lasts one cycle", done, 0);
        repeat (4) @(negedge clk);
        chk(!busy, "R2", "no run after start in done cycle", busy, 0);
        chk(present == held, "R9", "mask held after done", present, held);
    endtask

    initial begin
        logic [1:0] ecode [9];
        int         elen  [9];
        void'($urandom(32'h5A17C0DE));
        fault[0] = 0; fault[1] = 0; fault[2] = 0;
        repeat (3) @(negedge clk);
        chk(scl_lo == 0 && sda_lo == 0, "R1", "lines released in reset", {scl_lo, sda_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(present == 0 && !pass && !done && !busy, "R1", "outputs after reset",
            {present, pass, done, busy}, 0);

        // All buses good, three buses: check bus 0 waveform.
        run_case(1'b1, 1'b0, 1'b0);
        ecode = '{2'b00, 2'b11, 2'b01, 2'b00, 2'b10, 2'b00, 2'b01, 2'b11, 2'b01};
        elen  = '{0, T, 3 * T, 4 * T, 3 * T + 1, T, 2 * T + 1, T, 3 * T};
        for (int i = 1; i < 9; i++) begin
            string tag;
            tag = (i <= 2) ? "R5" : (i <= 4) ? "R6" : (i <= 6) ? "R7" : "R8";
            chk(seg_code[i] == ecode[i], tag, "bus0 segment level", seg_code[i], ecode[i]);
            chk(seg_len[i] == elen[i], tag, "bus0 segment length", seg_len[i], elen[i]);
        end
        chk(nseg == 9, "R8", "bus0 segments with closing STOP", nseg, 9);

        // Bus 0 fails pattern one: no closing STOP.
        fault[0] = 2; fault[1] = 0; fault[2] = 0;
        run_case(1'b1, 1'b0, 1'b0);
        chk(seg_code[4] == 2'b10 && seg_len[4] == 2 * T + 1, "R6", "pattern one hold",
            seg_len[4], 2 * T + 1);
        chk(nseg == 5, "R8", "failing bus skips closing STOP", nseg, 5);

        // Two-bus mode with a good third bus, stray start mid-run.
        fault[0] = 0; fault[1] = 0; fault[2] = 0;
        run_case(1'b0, 1'b1, 1'b0);

        // No bus present; start raised in the done cycle.
        fault[0] = 3; fault[1] = 5; fault[2] = 0;
        run_case(1'b0, 1'b0, 1'b1);

        // Only bus 2 present; pattern-two failures on buses 0 and 1.
        fault[0] = 1; fault[1] = 4; fault[2] = 0;
        run_case(1'b1, 1'b0, 1'b1);

        // Only bus 1 present: bit position.
        fault[0] = 4; fault[1] = 0; fault[2] = 2;
        run_case(1'b1, 1'b0, 1'b0);

        for (int r = 0; r < 14; r++) begin
            for (int b = 0; b < 3; b++) fault[b] = (($urandom % 2) == 0) ? 0 : int'($urandom % 6);
            run_case(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule